// File: doc/BRIEF.md
# Macro-pixel freeze and timestamp controller

This block sits between a pixel array and its column scanner. The pixels are grouped into macro-pixels of sixteen (two columns of eight). Each pixel holds its hit flag until the group is read out. Each group shows a combined hit indicator. On a bunch-crossing tick, every group whose indicator is set and that is not already frozen is frozen at the same moment. Each such group is tagged with the current value of an 8-bit wrapping time counter. The set of groups frozen together forms one scan request, which goes into a small queue of pending timestamps.

The scanner takes requests from the head of the queue over a valid/ready handshake. `scan_valid` is high whenever the queue holds a request. While `scan_ready` is low, the offered mask and timestamp stay unchanged. A cycle with both signals high counts as the scan-done handshake: it removes the request, clears the pixel flags of the groups in its mask and releases their freeze. Requests leave the queue in the order they were made, so scanner output comes out sorted by timestamp. The pixel hit inputs have no back-pressure: a hit on a group that is frozen is dropped and counted.

Top module: `mp_freeze_ctrl`

## Requirements
- R1: Pixel p belongs to group p/16, and its latched flag is bit p of `mp_pattern`. A one-cycle pulse on `pix_hit[p]` sets that flag in the next cycle, and the flag stays set until the group is released. `mp_hit[g]` is the OR of the sixteen latched flags of group g.
- R2: On a cycle with `bco_tick` high, provided the queue accepts the request, every group whose `mp_hit` is set and that is not frozen has its `mp_freeze` bit set in the next cycle. All other freeze bits are unchanged by the tick.
- R3: The time counter resets to 0 and advances by one on every tick, whether or not the tick freezes anything, wrapping from 255 to 0. A group frozen by a tick shows the counter value from before that tick's increment in `mp_ts[g*8 +: 8]`.
- R4: While a group is frozen, and during the tick cycle that freezes it, hit pulses on its pixels leave its pattern unchanged. Every such rejected pulse, counted per pixel per cycle, adds one to `lost_cnt`. The counter saturates at its maximum value.
- R5: A hit pulse that arrives in a tick cycle on a group that this tick does not freeze is latched. That group is then frozen by a later tick.
- R6: Each tick that freezes at least one group pushes one request, {mask of the groups just frozen, timestamp}. A tick that finds no candidate groups pushes nothing. A push and a pop may happen in the same cycle.
- R7: `scan_valid` is high exactly when the queue is not empty. While `scan_ready` is low, `scan_mask` and `scan_ts` hold steady. When `scan_valid` and `scan_ready` are both high, the next cycle shows the freeze bits and pattern bits of the groups in `scan_mask` cleared, and the head request removed.
- R8: The queue holds QDEPTH requests (default 4). Requests leave in the order they were pushed, so successive `scan_ts` values follow the tick order.
- R9: If the queue is full at the start of a tick cycle that has candidate groups, `ts_overflow` is high for exactly the next cycle. In that case no group is frozen, the candidates keep their flags, and the counter still advances.
- R10: After reset, all freeze, pattern, queue and counter state is zero, `scan_valid` is low and `ts_overflow` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_hit | input | NUM_MP*16 | Per-pixel hit pulses |
| bco_tick | input | 1 | One-cycle bunch-crossing tick |
| mp_hit | output | NUM_MP | Per-group combined hit indicator |
| mp_freeze | output | NUM_MP | Per-group freeze line |
| mp_pattern | output | NUM_MP*16 | Latched pixel flags |
| mp_ts | output | NUM_MP*8 | Per-group timestamp from its last freeze |
| scan_valid | output | 1 | A scan request is pending |
| scan_ready | input | 1 | Scanner accepts the request (scan done) |
| scan_mask | output | NUM_MP | Groups in the head request |
| scan_ts | output | 8 | Timestamp of the head request |
| ts_overflow | output | 1 | One-cycle pulse: a tick was lost because the queue was full |
| lost_cnt | output | 16 | Saturating count of rejected pixel hits |

## Verification
Two events can fall in the same cycle and need separate checks. The first is a tick that freezes a group while a fresh hit lands on that same group. The bench drives both in one cycle and expects the pattern to stay unchanged and `lost_cnt` to rise by one, while a hit on a group left unfrozen is kept for the next timestamp. The second is a release handshake in the same cycle as a tick that freezes another group. The bench expects the old group to be freed and the new request to become the head, carrying the next timestamp.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  localparam int PIX_PER_GROUP = 16;
  localparam int TS_BITS = 8;
  typedef logic [TS_BITS-1:0] tstamp_t;
endpackage

// File: rtl/mpf_group.sv
module mpf_group
  import mpf_pkg::*;
#(
  parameter int PIX = PIX_PER_GROUP,
  localparam int CW = $clog2(PIX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PIX-1:0] hit,
  input  logic           freeze_go,
  input  logic           release_go,
  input  tstamp_t        ts_in,
  output logic           any_hit,
  output logic           frozen,
  output logic [PIX-1:0] flags,
  output tstamp_t        ts_q,
  output logic [CW-1:0]  rejected
);
  logic blocked;

  // A group refuses new hits while frozen and during the cycle it is frozen.
  assign blocked  = frozen | freeze_go;
  assign any_hit  = |flags;
  assign rejected = blocked ? CW'($countones(hit)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      frozen <= 1'b0;
      ts_q   <= '0;
    end else begin
      if (release_go) begin
        flags  <= '0;
        frozen <= 1'b0;
      end else begin
        if (!blocked) flags <= flags | hit;
        if (freeze_go) begin
          frozen <= 1'b1;
          ts_q   <= ts_in;
        end
      end
    end
  end
endmodule

// File: rtl/mpf_ts_queue.sv
module mpf_ts_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   rd_ptr, wr_ptr;
  logic [CNTW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CNTW'(DEPTH));
  assign head  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mpf_lost_counter.sv
module mpf_lost_counter #(
  parameter int N  = 8,
  parameter int CW = 5,
  parameter int W  = 16,
  localparam int SW = W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*CW-1:0] counts,
  output logic [W-1:0]    total
);
  logic [SW-1:0] inc, nxt;

  always_comb begin
    inc = '0;
    for (int i = 0; i < N; i++) inc = inc + SW'(counts[i*CW +: CW]);
    nxt = SW'(total) + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   total <= '0;
    else if (nxt[W]) total <= '1;
    else          total <= nxt[W-1:0];
  end
endmodule

// File: rtl/mp_freeze_ctrl.sv
module mp_freeze_ctrl
  import mpf_pkg::*;
#(
  parameter int NUM_MP  = 8,
  parameter int QDEPTH  = 4,
  parameter int LOST_W  = 16,
  localparam int PIX    = PIX_PER_GROUP,
  localparam int NPIX   = NUM_MP * PIX,
  localparam int CW     = $clog2(PIX + 1),
  localparam int QW     = NUM_MP + TS_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPIX-1:0]           pix_hit,
  input  logic                      bco_tick,
  output logic [NUM_MP-1:0]         mp_hit,
  output logic [NUM_MP-1:0]         mp_freeze,
  output logic [NPIX-1:0]           mp_pattern,
  output logic [NUM_MP*TS_BITS-1:0] mp_ts,
  output logic                      scan_valid,
  input  logic                      scan_ready,
  output logic [NUM_MP-1:0]         scan_mask,
  output logic [TS_BITS-1:0]        scan_ts,
  output logic                      ts_overflow,
  output logic [LOST_W-1:0]         lost_cnt
);
  tstamp_t           ts_cnt;
  logic [NUM_MP-1:0] candidates, freeze_go, release_go;
  logic [NUM_MP*CW-1:0] rej_counts;
  logic              q_full, q_empty, accept, drop, pop;
  logic [QW-1:0]     q_head;

  assign candidates = mp_hit & ~mp_freeze;
  assign accept     = bco_tick && (|candidates) && !q_full;
  assign drop       = bco_tick && (|candidates) && q_full;
  assign freeze_go  = accept ? candidates : '0;
  assign pop        = scan_valid && scan_ready;
  assign release_go = pop ? scan_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_cnt      <= '0;
      ts_overflow <= 1'b0;
    end else begin
      if (bco_tick) ts_cnt <= ts_cnt + 1'b1;
      ts_overflow <= drop;
    end
  end

  for (genvar g = 0; g < NUM_MP; g++) begin : g_grp
    mpf_group #(.PIX(PIX)) u_grp (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (pix_hit[g*PIX +: PIX]),
      .freeze_go  (freeze_go[g]),
      .release_go (release_go[g]),
      .ts_in      (ts_cnt),
      .any_hit    (mp_hit[g]),
      .frozen     (mp_freeze[g]),
      .flags      (mp_pattern[g*PIX +: PIX]),
      .ts_q       (mp_ts[g*TS_BITS +: TS_BITS]),
      .rejected   (rej_counts[g*CW +: CW])
    );
  end

  mpf_ts_queue #(.DEPTH(QDEPTH), .W(QW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data ({candidates, ts_cnt}),
    .pop       (pop),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  assign scan_valid = !q_empty;
  assign scan_mask  = q_head[QW-1 -: NUM_MP];
  assign scan_ts    = q_head[TS_BITS-1:0];

  mpf_lost_counter #(.N(NUM_MP), .CW(CW), .W(LOST_W)) u_lost (
    .clk    (clk),
    .rst_n  (rst_n),
    .counts (rej_counts),
    .total  (lost_cnt)
  );
endmodule

// File: rtl/mp_freeze_ctrl_chk.sv
module mp_freeze_ctrl_chk #(
  parameter int NUM_MP = 8,
  parameter int LOST_W = 16,
  parameter int TS_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bco_tick,
  input logic [NUM_MP-1:0] mp_freeze,
  input logic              scan_valid,
  input logic              scan_ready,
  input logic [NUM_MP-1:0] scan_mask,
  input logic [TS_W-1:0]   scan_ts,
  input logic              ts_overflow,
  input logic [LOST_W-1:0] lost_cnt
);
  // R2: new freeze bits appear only after a tick
  p_freeze_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bco_tick |=> ((mp_freeze & ~$past(mp_freeze)) == '0));

  // R7: freeze bits drop only after a scan handshake
  p_release_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_valid && scan_ready) |=> ((mp_freeze & $past(mp_freeze)) == $past(mp_freeze)));

  // R7: a stalled request holds steady
  p_stall_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && !scan_ready) |=> (scan_valid && $stable(scan_mask) && $stable(scan_ts)));

  // R6: every pending request names frozen groups only
  p_mask_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid |-> ((scan_mask & ~mp_freeze) == '0 && scan_mask != '0));

  // R9: overflow only follows a tick
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bco_tick |=> !ts_overflow);

  // R4: lost count never decreases
  p_lost_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lost_cnt >= $past(lost_cnt)));
endmodule

bind mp_freeze_ctrl mp_freeze_ctrl_chk #(.NUM_MP(NUM_MP), .LOST_W(LOST_W), .TS_W(mpf_pkg::TS_BITS)) u_chk (.*);

// File: tb/mp_freeze_ctrl_test.sv
module mp_freeze_ctrl_test;
  localparam int NUM_MP = 8;
  localparam int PIX    = 16;
  localparam int NPIX   = NUM_MP * PIX;
  localparam int QDEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPIX-1:0] pix_hit = '0;
  logic bco_tick = 1'b0;
  logic scan_ready = 1'b0;
  logic [NUM_MP-1:0] mp_hit, mp_freeze, scan_mask;
  logic [NPIX-1:0] mp_pattern;
  logic [NUM_MP*8-1:0] mp_ts;
  logic scan_valid, ts_overflow;
  logic [7:0] scan_ts;
  logic [15:0] lost_cnt;

  int n_chk = 0, n_fail = 0;
  int ticks = 0;
  int lost_exp = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mp_freeze_ctrl #(.NUM_MP(NUM_MP), .QDEPTH(QDEPTH), .LOST_W(16)) uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [NPIX-1:0] h, input logic t, input logic r);
    pix_hit = h; bco_tick = t; scan_ready = r;
    @(posedge clk); #1;
    pix_hit = '0; bco_tick = 1'b0; scan_ready = 1'b0;
    if (t) ticks++;
  endtask

  function automatic logic [NPIX-1:0] pbit(input int g, input int k);
    logic [NPIX-1:0] v = '0;
    v[g*PIX + k] = 1'b1;
    return v;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [NPIX-1:0] h;
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10: reset state
    chk("R10 freeze", 64'(mp_freeze), 0);
    chk("R10 valid", 64'(scan_valid), 0);
    chk("R10 lost", 64'(lost_cnt), 0);
    chk("R10 ovf", 64'(ts_overflow), 0);
    chk("R10 pattern", 64'(|mp_pattern), 0);

    // Sweep every group mask
    for (int m = 0; m < 256; m++) begin
      h = '0;
      for (int g = 0; g < NUM_MP; g++) if (m[g]) h |= pbit(g, (m + g) % PIX);
      cyc(h, 1'b0, 1'b0);
      chk("R1 fast-or", 64'(mp_hit), 64'(m));
      cyc('0, 1'b1, 1'b0);
      chk("R2 freeze set", 64'(mp_freeze), 64'(m));
      chk("R6 valid", 64'(scan_valid), 64'(m != 0));
      if (m != 0) begin
        chk("R6 mask", 64'(scan_mask), 64'(m));
        chk("R3 scan ts", 64'(scan_ts), 64'((ticks - 1) & 255));
        for (int g = 0; g < NUM_MP; g++) if (m[g]) begin
          chk("R3 group ts", 64'(mp_ts[g*8 +: 8]), 64'((ticks - 1) & 255));
          chk("R1 pattern", 64'(mp_pattern[g*PIX +: PIX]), 64'(16'(1) << ((m + g) % PIX)));
        end
        h = '0;
        for (int g = 0; g < NUM_MP; g++) if (m[g]) h[g*PIX +: PIX] = '1;
        cyc(h, 1'b0, 1'b0);
        lost_exp += 16 * $countones(m[7:0]);
        chk("R4 lost", 64'(lost_cnt), 64'(lost_exp));
        for (int g = 0; g < NUM_MP; g++) if (m[g])
          chk("R4 frozen pattern", 64'($countones(mp_pattern[g*PIX +: PIX])), 1);
        cyc('0, 1'b0, 1'b1);
        chk("R7 release freeze", 64'(mp_freeze), 0);
        chk("R7 release pattern", 64'(|mp_pattern), 0);
        chk("R7 valid low", 64'(scan_valid), 0);
      end
    end

    // R3: counter wrapped after 256 ticks
    cyc(pbit(0, 0), 1'b0, 1'b0);
    cyc('0, 1'b1, 1'b0);
    chk("R3 wrap", 64'(scan_ts), 0);
    cyc('0, 1'b0, 1'b1);

    // Fill the queue
    base = ticks;
    for (int e = 0; e < QDEPTH; e++) begin
      cyc(pbit(e, 0), 1'b0, 1'b0);
      cyc('0, 1'b1, 1'b0);
    end
    chk("R2 four frozen", 64'(mp_freeze), 64'h0F);
    chk("R8 head oldest", 64'(scan_mask), 1);
    cyc(pbit(4, 1), 1'b0, 1'b0);
    cyc('0, 1'b1, 1'b0);
    chk("R9 ovf pulse", 64'(ts_overflow), 1);
    chk("R9 not frozen", 64'(mp_freeze[4]), 0);
    chk("R9 flags kept", 64'(mp_hit[4]), 1);
    cyc('0, 1'b0, 1'b0);
    chk("R9 ovf one cycle", 64'(ts_overflow), 0);
    chk("R7 stall mask", 64'(scan_mask), 1);
    chk("R7 stall ts", 64'(scan_ts), 64'(base & 255));
    for (int e = 0; e < QDEPTH; e++) begin
      chk("R8 order mask", 64'(scan_mask), 64'(1 << e));
      chk("R8 order ts", 64'(scan_ts), 64'((base + e) & 255));
      cyc('0, 1'b0, 1'b1);
      chk("R7 released", 64'(mp_freeze[e]), 0);
    end
    chk("R8 drained", 64'(scan_valid), 0);
    cyc('0, 1'b1, 1'b0);
    chk("R9 later freeze", 64'(mp_freeze), 64'h10);
    chk("R3 counter ran on", 64'(scan_ts), 64'((ticks - 1) & 255));
    cyc('0, 1'b0, 1'b1);

    // Same-cycle hit and freeze
    cyc(pbit(0, 2), 1'b0, 1'b0);
    cyc(pbit(0, 5) | pbit(1, 3), 1'b1, 1'b0);
    lost_exp += 1;
    chk("R2 only grp0", 64'(mp_freeze), 1);
    chk("R4 same-cycle pattern", 64'(mp_pattern[15:0]), 64'(16'h0004));
    chk("R4 same-cycle lost", 64'(lost_cnt), 64'(lost_exp));
    chk("R5 kept hit", 64'(mp_pattern[31:16]), 64'(16'h0008));
    // Pop and push in one cycle
    cyc('0, 1'b1, 1'b1);
    chk("R6 push+pop freeze", 64'(mp_freeze), 2);
    chk("R6 push+pop mask", 64'(scan_mask), 2);
    chk("R5 next ts", 64'(scan_ts), 64'((ticks - 1) & 255));
    chk("R7 grp0 cleared", 64'(mp_pattern[15:0]), 0);
    cyc('0, 1'b0, 1'b1);
    chk("R7 all clear", 64'({scan_valid, mp_freeze}), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule